// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is one DMA channel. It copies data between a 24-bit memory address and a fixed 8-bit peripheral address. Each request moves one unit, either a byte or a 16-bit word. A transfer is two bus cycles: a read from the source, then a write of that data to the destination.

A configuration strobe loads the channel's settings and enables it. The settings are the mode, the unit size, the step direction, the transfer direction, the trigger source, both addresses and the transfer count. After that, each pulse on the selected trigger line starts one transfer.

There are three modes:
- In stepping mode the memory address moves after every transfer.
- In fixed mode the memory address stays where it was loaded.
- In both of those modes the channel disables itself and raises a one-cycle done pulse after the last transfer.
- In repeat mode the channel restarts from its loaded address and count each time the count runs out, and it never stops on its own.

The channel ignores a configuration strobe while a bus cycle is active, so software loads it between transfers.

Top module: `sdma_channel`

## Requirements
- R1: After reset, bus_req, ch_en and done_irq are 0. A cfg_load pulse taken while no bus cycle is active captures all cfg_* inputs and sets ch_en to 1 from the next cycle.
- R2: Only a one-cycle high on trig_in[cfg_trig_sel] requests a transfer. Pulses on the other trig_in bits are ignored. A select value of 6 or 7 matches nothing. Any trigger is ignored while ch_en is 0.
- R3: A transfer is one read cycle (bus_we=0) at the source address followed by one write cycle (bus_we=1) at the destination address. bus_req, bus_addr and bus_we hold steady until bus_rdy is sampled high. For words, bus_word=1 and bus_wdata carries all 16 bits that were read. For bytes, bus_word=0 and bus_wdata={8'h00, read data[7:0]}.
- R4: With cfg_per_to_mem=0, memory is the source and the peripheral is the destination. With cfg_per_to_mem=1, the roles swap. The peripheral bus address is {16'hFFFF, peripheral address}.
- R5: cfg_mode encodes the mode: 0 is stepping, 1 is fixed, 2 is repeat, and 3 behaves as stepping. In stepping and repeat modes, the memory address moves by 1 (byte) or 2 (word) after each transfer. It moves up when cfg_down=0 and down when cfg_down=1, wrapping modulo 2^24.
- R6: In fixed mode, every transfer uses the loaded memory address.
- R7: Stepping and fixed modes perform cfg_count transfers, where a count of 0 means 65,536. After the write handshake of the last transfer, ch_en is 0 and done_irq is 1 for exactly one cycle. Before that, done_irq stays 0.
- R8: Repeat mode takes its count (1 to 255) from cfg_count[7:0]. After that many transfers, the address and count return to their loaded values, ch_en stays 1, and done_irq never rises.
- R9: A trigger that arrives during a transfer is held and starts one further transfer as soon as the current one ends. This includes a trigger in the very cycle a held request is taken. Further triggers that arrive before that transfer starts are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the settings below and enable the channel |
| cfg_mode | input | 2 | 0 stepping, 1 fixed, 2 repeat, 3 as stepping |
| cfg_word | input | 1 | 1 moves 16-bit words, 0 moves bytes |
| cfg_down | input | 1 | 1 steps the memory address downward |
| cfg_per_to_mem | input | 1 | 1 reads the peripheral and writes memory |
| cfg_trig_sel | input | 3 | Index of the trig_in line that requests transfers |
| cfg_mem_addr | input | 24 | Initial memory address |
| cfg_per_addr | input | 8 | Peripheral address |
| cfg_count | input | 16 | Transfer count (low 8 bits in repeat mode) |
| trig_in | input | 6 | Request strobes: timer events 0-3, serial transmit-empty, serial receive-full/external |
| bus_req | output | 1 | A bus cycle is active |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_word | output | 1 | 1 for a 16-bit access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken when bus_rdy is high |
| bus_rdy | input | 1 | Ends the active bus cycle |
| ch_en | output | 1 | Channel enabled |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
A new trigger pulse can land in the same cycle in which the channel takes its already held request and starts a read. The held flag must then stay set rather than be cleared by the take. The bench provokes this by pulsing the selected trigger on two consecutive cycles from idle, then a third time during the read. It judges the result by requiring exactly two back-to-back transfers, followed by a quiet bus. Repeat-mode reload and the final transfer's completion also coincide with a step of the address register. Here the bench checks that the address sequence restarts at the loaded value and that done_irq stays low.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    MODE_STEP   = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_RPT    = 2'd2,
    MODE_STEP_B = 2'd3
  } sdma_mode_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  // byte count of one transfer unit
  function automatic logic [2:0] unit_bytes(input logic word);
    return word ? 3'd2 : 3'd1;
  endfunction

  // memory address moves after each transfer
  function automatic logic mode_steps(input sdma_mode_e m);
    return m != MODE_FIXED;
  endfunction

  // count exhaustion restores the loaded state instead of stopping
  function automatic logic mode_reloads(input sdma_mode_e m);
    return m == MODE_RPT;
  endfunction

endpackage

// File: rtl/sdma_req_latch.sv
module sdma_req_latch #(
  parameter int NTRIG = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             arm,
  input  logic             take,
  input  logic             flush,
  output logic             pend
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (trig_sel == SEL_W'(i)) hit = trig_in[i];
    end
    hit = hit & arm;
  end

  // a new strobe wins over the take in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (flush)  pend <= 1'b0;
    else if (hit)    pend <= 1'b1;
    else if (take)   pend <= 1'b0;
  end

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take && !flush |=> pend);  // R9
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !flush |=> pend);  // R9

endmodule

// File: rtl/sdma_addr_cnt.sv
module sdma_addr_cnt
  import sdma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int CNT_W  = 16,
  parameter int RPT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  sdma_mode_e        load_mode,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              step,
  input  sdma_mode_e        mode,
  input  logic              word,
  input  logic              down,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              last,
  output logic              reload_ev
);

  logic [MEM_AW-1:0] base_addr;
  logic [MEM_AW-1:0] stride;
  logic [MEM_AW-1:0] addr_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  base_cnt;
  logic [CNT_W-1:0]  cnt_init;

  assign cnt_init  = mode_reloads(load_mode) ? CNT_W'(load_count[RPT_W-1:0]) : load_count;
  assign stride    = MEM_AW'(unit_bytes(word));
  assign last      = (cnt_q == CNT_W'(1));
  assign reload_ev = step && last && mode_reloads(mode);

  always_comb begin
    if (!mode_steps(mode)) addr_next = mem_addr;
    else if (down)         addr_next = mem_addr - stride;
    else                   addr_next = mem_addr + stride;
  end

  // a loaded count of 0 wraps past 1 only after 2^CNT_W transfers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      base_addr <= '0;
      cnt_q     <= '0;
      base_cnt  <= '0;
    end else if (load) begin
      mem_addr  <= load_addr;
      base_addr <= load_addr;
      cnt_q     <= cnt_init;
      base_cnt  <= cnt_init;
    end else if (step) begin
      if (reload_ev) begin
        mem_addr <= base_addr;
        cnt_q    <= base_cnt;
      end else begin
        mem_addr <= addr_next;
        cnt_q    <= cnt_q - CNT_W'(1);
      end
    end
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    step && !mode_steps(mode) |=> $stable(mem_addr));  // R6
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> cnt_q == $past(cnt_q) - CNT_W'(1));  // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> (cnt_q == base_cnt) && (mem_addr == base_addr));  // R8
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode_steps(mode) && !last |=>
      (MEM_AW'(mem_addr - $past(mem_addr)) == stride) ||
      (MEM_AW'($past(mem_addr) - mem_addr) == stride));  // R5

endmodule

// File: rtl/sdma_xfer_fsm.sv
module sdma_xfer_fsm
  import sdma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              word,
  input  logic [MEM_AW-1:0] src_addr,
  input  logic [MEM_AW-1:0] dst_addr,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              take,
  output logic              xfer_done,
  output logic              busy
);

  xfer_state_e state;
  logic        read_done;
  logic [DATA_W-1:0] data_q;

  assign take      = (state == XS_IDLE) && go;
  assign read_done = (state == XS_READ) && bus_rdy;
  assign xfer_done = (state == XS_WRITE) && bus_rdy;
  assign bus_req   = (state != XS_IDLE);
  assign bus_we    = (state == XS_WRITE);
  assign bus_addr  = (state == XS_WRITE) ? dst_addr : src_addr;
  assign bus_wdata = data_q;
  assign busy      = bus_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XS_IDLE;
    end else begin
      case (state)
        XS_IDLE:  if (go)      state <= XS_READ;
        XS_READ:  if (bus_rdy) state <= XS_WRITE;
        XS_WRITE: if (bus_rdy) state <= XS_IDLE;
        default:               state <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (read_done) data_q <= word ? bus_rdata
                                       : {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
  end

  AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we));  // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_req && !bus_we && bus_rdy));  // R3

endmodule

// File: rtl/sdma_channel.sv
module sdma_channel
  import sdma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int PER_AW = 8,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int RPT_W  = 8,
  parameter int NTRIG  = 6,
  parameter int SEL_W  = 3,
  parameter logic [MEM_AW-PER_AW-1:0] PER_HI = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_word,
  input  logic              cfg_down,
  input  logic              cfg_per_to_mem,
  input  logic [SEL_W-1:0]  cfg_trig_sel,
  input  logic [MEM_AW-1:0] cfg_mem_addr,
  input  logic [PER_AW-1:0] cfg_per_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [NTRIG-1:0]  trig_in,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  output logic              ch_en,
  output logic              done_irq
);

  sdma_mode_e        mode_q;
  logic              word_q, down_q, to_mem_q;
  logic [SEL_W-1:0]  sel_q;
  logic [PER_AW-1:0] per_q;

  logic              busy, take, xfer_done, pend, last, reload_ev;
  logic              cfg_accept, finish;
  logic [MEM_AW-1:0] mem_addr, per_full, src_addr, dst_addr;

  assign cfg_accept = cfg_load && !busy;
  assign finish     = xfer_done && last && !mode_reloads(mode_q);
  assign per_full   = {PER_HI, per_q};
  assign src_addr   = to_mem_q ? per_full : mem_addr;
  assign dst_addr   = to_mem_q ? mem_addr : per_full;
  assign bus_word   = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_STEP;
      word_q   <= 1'b0;
      down_q   <= 1'b0;
      to_mem_q <= 1'b0;
      sel_q    <= '0;
      per_q    <= '0;
    end else if (cfg_accept) begin
      mode_q   <= sdma_mode_e'(cfg_mode);
      word_q   <= cfg_word;
      down_q   <= cfg_down;
      to_mem_q <= cfg_per_to_mem;
      sel_q    <= cfg_trig_sel;
      per_q    <= cfg_per_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en    <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= finish;
      if (cfg_accept)  ch_en <= 1'b1;
      else if (finish) ch_en <= 1'b0;
    end
  end

  sdma_req_latch #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(sel_q),
    .arm(ch_en), .take(take), .flush(cfg_accept || finish), .pend(pend)
  );

  sdma_addr_cnt #(.MEM_AW(MEM_AW), .CNT_W(CNT_W), .RPT_W(RPT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(cfg_accept), .load_mode(sdma_mode_e'(cfg_mode)),
    .load_addr(cfg_mem_addr), .load_count(cfg_count), .step(xfer_done),
    .mode(mode_q), .word(word_q), .down(down_q),
    .mem_addr(mem_addr), .last(last), .reload_ev(reload_ev)
  );

  sdma_xfer_fsm #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(ch_en && pend), .word(word_q),
    .src_addr(src_addr), .dst_addr(dst_addr), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .take(take), .xfer_done(xfer_done), .busy(busy)
  );

  AST_DONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !ch_en);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);  // R7
  AST_RPT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_RPT |-> !done_irq);  // R8
  AST_RELOAD_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> ch_en);  // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !bus_req);  // R2

endmodule

// File: tb/test_sdma_channel.sv
module test_sdma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_word = 1'b0, cfg_down = 1'b0, cfg_per_to_mem = 1'b0;
  logic [2:0]  cfg_trig_sel = '0;
  logic [23:0] cfg_mem_addr = '0;
  logic [7:0]  cfg_per_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [5:0]  trig_in = '0;
  logic        bus_req, bus_we, bus_word, bus_rdy = 1'b0;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        ch_en, done_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [15:0] rdpat(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[23:16] + a[15:8]};
  endfunction

  assign bus_rdata = bus_rdy ? rdpat(bus_addr) : 16'h0000;

  sdma_channel i_sdma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_word(cfg_word), .cfg_down(cfg_down), .cfg_per_to_mem(cfg_per_to_mem),
    .cfg_trig_sel(cfg_trig_sel), .cfg_mem_addr(cfg_mem_addr), .cfg_per_addr(cfg_per_addr),
    .cfg_count(cfg_count), .trig_in(trig_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .ch_en(ch_en), .done_irq(done_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory address of the i-th transfer, computed as an offset from the start
  function automatic logic [23:0] addr_at(input logic [1:0] mode, input bit word, input bit down,
                                          input logic [23:0] a, input int i, input logic [15:0] cnt);
    int k;
    int off;
    if (mode == 2'd1) return a;
    k = (mode == 2'd2) ? (i % int'(cnt[7:0])) : i;
    off = k * (word ? 2 : 1);
    return down ? a - 24'(off) : a + 24'(off);
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig(input int idx);
    trig_in[idx] = 1'b1;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic serve(input bit we, input logic [23:0] addr, input bit word,
                       input logic [15:0] data, input string atag);
    int n = 0;
    int k;
    while (!bus_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(bus_req, "R3", "bus cycle start", bus_req, 1);
    check(bus_we == we, "R3", "read/write order", bus_we, we);
    check(bus_addr == addr, atag, "bus address", bus_addr, addr);
    check(bus_word == word, "R3", "unit size", bus_word, word);
    if (we) check(bus_wdata == data, "R3", "write data", bus_wdata, data);
    k = $urandom % 3;
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      check(bus_req && bus_addr == addr, "R3", "held until ready", bus_addr, addr);
    end
    bus_rdy = 1'b1;
    @(negedge clk);
    bus_rdy = 1'b0;
  endtask

  task automatic one_xfer(input bit to_mem, input bit word, input logic [23:0] maddr,
                          input logic [7:0] paddr, input string mtag);
    logic [23:0] pfull;
    logic [23:0] src;
    logic [15:0] d;
    pfull = {16'hFFFF, paddr};
    src = to_mem ? pfull : maddr;
    d = word ? rdpat(src) : {8'h00, rdpat(src)[7:0]};
    serve(1'b0, src, word, 16'h0, to_mem ? "R4" : mtag);
    serve(1'b1, to_mem ? maddr : pfull, word, d, to_mem ? mtag : "R4");
  endtask

  task automatic load(input logic [1:0] mode, input bit word, input bit down, input bit to_mem,
                      input int sel, input logic [23:0] maddr, input logic [7:0] paddr,
                      input logic [15:0] cnt);
    cfg_mode = mode; cfg_word = word; cfg_down = down; cfg_per_to_mem = to_mem;
    cfg_trig_sel = 3'(sel); cfg_mem_addr = maddr; cfg_per_addr = paddr; cfg_count = cnt;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(ch_en == 1'b1, "R1", "enable after load", ch_en, 1);
  endtask

  task automatic run_job(input logic [1:0] mode, input bit word, input bit down, input bit to_mem,
                         input int sel, input logic [23:0] maddr, input logic [7:0] paddr,
                         input logic [15:0] cnt, input int nx);
    string mtag;
    bit ends;
    mtag = (mode == 2'd1) ? "R6" : (mode == 2'd2) ? "R8" : "R5";
    ends = (mode != 2'd2);
    load(mode, word, down, to_mem, sel, maddr, paddr, cnt);
    for (int i = 0; i < nx; i++) begin
      pulse_trig(sel);
      one_xfer(to_mem, word, addr_at(mode, word, down, maddr, i, cnt), paddr, mtag);
      if (ends && i == nx - 1) begin
        check(done_irq == 1'b1, "R7", "done pulse", done_irq, 1);
        check(ch_en == 1'b0, "R7", "disable at end", ch_en, 0);
        @(negedge clk);
        check(done_irq == 1'b0, "R7", "done one cycle", done_irq, 0);
      end else begin
        check(done_irq == 1'b0, ends ? "R7" : "R8", "no early done", done_irq, 0);
        check(ch_en == 1'b1, ends ? "R7" : "R8", "stays enabled", ch_en, 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bus_req == 1'b0, "R1", "reset bus_req", bus_req, 0);
    check(ch_en == 1'b0, "R1", "reset ch_en", ch_en, 0);
    check(done_irq == 1'b0, "R1", "reset done_irq", done_irq, 0);

    // R5 stepping up bytes, memory to peripheral
    run_job(2'd0, 1'b0, 1'b0, 1'b0, 1, 24'h012340, 8'h21, 16'd3, 3);
    // R2 trigger while disabled
    pulse_trig(1);
    wait_neg(5);
    check(bus_req == 1'b0, "R2", "trigger while disabled", bus_req, 0);

    // R6 fixed mode, words, peripheral to memory
    run_job(2'd1, 1'b1, 1'b0, 1'b1, 4, 24'hABCDE0, 8'h7E, 16'd2, 2);
    // R5 downward wrap through zero
    run_job(2'd0, 1'b0, 1'b1, 1'b0, 0, 24'h000001, 8'h03, 16'd3, 3);
    // R8 repeat words downward, count 3
    run_job(2'd2, 1'b1, 1'b1, 1'b0, 2, 24'h000100, 8'h40, 16'd3, 7);

    // R2 unselected lines ignored
    load(2'd0, 1'b1, 1'b0, 1'b0, 2, 24'h500000, 8'h10, 16'd1);
    pulse_trig(5);
    pulse_trig(0);
    wait_neg(5);
    check(bus_req == 1'b0, "R2", "unselected trigger", bus_req, 0);
    pulse_trig(2);
    one_xfer(1'b0, 1'b1, 24'h500000, 8'h10, "R5");
    check(done_irq == 1'b1, "R7", "count one done", done_irq, 1);
    @(negedge clk);

    // R2 out-of-range select matches nothing
    load(2'd0, 1'b0, 1'b0, 1'b0, 7, 24'h000010, 8'h10, 16'd1);
    trig_in = '1;
    @(negedge clk);
    trig_in = '0;
    wait_neg(5);
    check(bus_req == 1'b0, "R2", "select 7 ignored", bus_req, 0);

    // R9 held request taken in same cycle as new strobe, no queueing beyond one
    load(2'd0, 1'b0, 1'b0, 1'b0, 3, 24'h000200, 8'h55, 16'd3);
    pulse_trig(3);
    pulse_trig(3);
    pulse_trig(3);
    one_xfer(1'b0, 1'b0, 24'h000200, 8'h55, "R9");
    one_xfer(1'b0, 1'b0, 24'h000201, 8'h55, "R9");
    wait_neg(6);
    check(bus_req == 1'b0, "R9", "no second queued request", bus_req, 0);
    check(ch_en == 1'b1, "R9", "still enabled", ch_en, 1);
    pulse_trig(3);
    one_xfer(1'b0, 1'b0, 24'h000202, 8'h55, "R9");
    check(done_irq == 1'b1, "R7", "done after held sequence", done_irq, 1);
    @(negedge clk);

    // R7 count 0 does not end early
    load(2'd0, 1'b0, 1'b0, 1'b0, 0, 24'h100000, 8'h01, 16'd0);
    for (int i = 0; i < 300; i++) begin
      pulse_trig(0);
      one_xfer(1'b0, 1'b0, 24'h100000 + 24'(i), 8'h01, "R5");
    end
    check(ch_en == 1'b1 && done_irq == 1'b0, "R7", "count 0 still running", ch_en, 1);

    // random jobs, mode 3 included as stepping
    for (int j = 0; j < 30; j++) begin
      logic [1:0]  m;
      logic [15:0] c;
      m = 2'($urandom % 4);
      c = 16'(1 + $urandom % 5);
      run_job(m, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 6),
              24'($urandom), 8'($urandom), c, (m == 2'd2) ? int'(c) * 2 + 1 : int'(c));
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule